// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits behind the write port of a parallel NOR flash device. It watches every bus write, follows the multi-cycle command protocol, and decides when a word program or a whole-array erase should begin. When a sequence completes, it raises a one-clock start pulse toward the embedded-operation engine. For a program, it also holds the target address and data.

The block has two modes, read and unlock-bypass. In bypass mode a program takes only two writes instead of four. The controller leaves bypass only through a dedicated two-write exit. While the engine reports busy, every write is dropped. A hardware reset returns the block to read mode at once, including in the middle of a sequence.

States and transitions. All of them happen only on an accepted write, which is a write strobe while busy is low:
- IDLE_READ goes to GOT_UNLK1 when the write is AAh at word address 555h.
- GOT_UNLK1 goes to GOT_UNLK2 when the write is 55h at 2AAh. Any other write goes back to IDLE_READ.
- GOT_UNLK2 branches on the command code:
  - A0h goes to PGM_WAIT_DATA.
  - 80h goes to ERS_ARMED.
  - 20h goes to BYP_IDLE.
  - Any other code goes back to IDLE_READ.
- PGM_WAIT_DATA fires a program on the next write and returns to IDLE_READ.
- ERS_ARMED goes to ERS_UNLK1 on AAh at 555h. Any other write returns to IDLE_READ.
- ERS_UNLK1 goes to ERS_UNLK2 on 55h at 2AAh. Any other write returns to IDLE_READ.
- ERS_UNLK2 fires a chip erase on 10h and returns to IDLE_READ either way.
- BYP_IDLE goes to BYP_WAIT_DATA on A0h and to BYP_EXIT_ARMED on 90h. Any other write is ignored.
- BYP_WAIT_DATA fires a program on the next write and returns to BYP_IDLE.
- BYP_EXIT_ARMED goes to IDLE_READ on 00h. Any other write returns to BYP_IDLE.

Top module: `nor_cmd_decoder`

## Requirements
- R1: While and after hardware reset (`hw_rst_n` low, asynchronous), `bypass_mode`, `prog_start` and `erase_start` are 0.
- R2: The writes AAh@555h, 55h@2AAh, then A0h at any address, then a write of A/D produce `prog_start` high in the cycle after that last write. `prog_addr`=A and `prog_data`=D at that point, and `bypass_mode` stays 0.
- R3: The six writes AAh@555h, 55h@2AAh, 80h, AAh@555h, 55h@2AAh, 10h produce `erase_start` high in the cycle after the sixth write.
- R4: The writes AAh@555h, 55h@2AAh, 20h set `bypass_mode` to 1 after the third write.
- R5: In bypass mode, A0h followed by a write of A/D produces `prog_start` with `prog_addr`=A and `prog_data`=D, and bypass mode is kept.
- R6: In bypass mode, 90h then 00h returns to read mode (`bypass_mode`=0). 90h followed by any other value keeps bypass mode. Writes other than A0h and 90h, including F0h and unlock cycles, start nothing and keep bypass mode.
- R7: A write while `busy` is high starts nothing and leaves the sequence state unchanged.
- R8: Outside bypass, a write that does not match the expected next cycle returns the decoder to read mode without starting an operation. This includes a wrong unlock address or F0h in a command cycle. Data cycles of a program accept any value.
- R9: Each start pulse lasts exactly one clock. `prog_addr` and `prog_data` hold until the next program start.
- R10: A hardware reset in the middle of a sequence, or in the same cycle as its final write, aborts it with no start pulse. A reset also leaves bypass mode.
- R11: Command codes are compared on `wr_data[7:0]` only. Unlock addresses are compared on the full `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write |
| busy | input | 1 | Embedded operation in progress |
| prog_start | output | 1 | One-cycle program start pulse |
| erase_start | output | 1 | One-cycle chip erase start pulse |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | DATA_W | Latched program data |
| bypass_mode | output | 1 | 1 in unlock-bypass mode, 0 in read mode |

## Verification
The bench makes two collisions happen on purpose.

In the first, the final data write of a program and the hardware reset are driven in the same cycle. The asynchronous reset must win, so the scoreboard must see no program pulse, and the following full program must still work.

In the second, busy is raised in the middle of a sequence. The write that lands during busy must neither start anything nor advance the state, which the bench judges by completing the interrupted sequence after busy falls and expecting exactly one program.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam logic [10:0] UNLK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLK_ADDR_B = 11'h2AA;

    localparam logic [7:0] CODE_UNLK_A    = 8'hAA;
    localparam logic [7:0] CODE_UNLK_B    = 8'h55;
    localparam logic [7:0] CODE_PGM       = 8'hA0;
    localparam logic [7:0] CODE_ERS_SETUP = 8'h80;
    localparam logic [7:0] CODE_CHIP_ERS  = 8'h10;
    localparam logic [7:0] CODE_BYP_ENTER = 8'h20;
    localparam logic [7:0] CODE_BYP_EXIT1 = 8'h90;
    localparam logic [7:0] CODE_BYP_EXIT2 = 8'h00;

    typedef enum logic [3:0] {
        IDLE_READ,
        GOT_UNLK1,
        GOT_UNLK2,
        PGM_WAIT_DATA,
        ERS_ARMED,
        ERS_UNLK1,
        ERS_UNLK2,
        BYP_IDLE,
        BYP_WAIT_DATA,
        BYP_EXIT_ARMED
    } dec_state_t;

    typedef struct packed {
        logic unlk_a;
        logic unlk_b;
        logic pgm;
        logic ers_setup;
        logic chip_ers;
        logic byp_enter;
        logic byp_exit1;
        logic byp_exit2;
    } cyc_flags_t;

endpackage

// File: rtl/nor_cycle_classify.sv
module nor_cycle_classify
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cyc_flags_t        flags
);
    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(UNLK_ADDR_A);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(UNLK_ADDR_B);

    logic [7:0] code;
    logic       at_a;
    logic       at_b;

    always_comb begin
        code            = wr_data[7:0];
        at_a            = (wr_addr == ADDR_A);
        at_b            = (wr_addr == ADDR_B);
        flags.unlk_a    = at_a && (code == CODE_UNLK_A);
        flags.unlk_b    = at_b && (code == CODE_UNLK_B);
        flags.pgm       = (code == CODE_PGM);
        flags.ers_setup = (code == CODE_ERS_SETUP);
        flags.chip_ers  = (code == CODE_CHIP_ERS);
        flags.byp_enter = (code == CODE_BYP_ENTER);
        flags.byp_exit1 = (code == CODE_BYP_EXIT1);
        flags.byp_exit2 = (code == CODE_BYP_EXIT2);
    end

    if (DATA_W > 8) begin : g_upper_unused
        logic unused_upper;
        assign unused_upper = ^wr_data[DATA_W-1:8];
    end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       hw_rst_n,
    input  logic       wr_en,
    input  logic       busy,
    input  cyc_flags_t flags,
    output logic       fire_prog,
    output logic       fire_erase,
    output logic       in_bypass
);
    dec_state_t state_q;
    dec_state_t state_d;
    logic       accept;

    assign accept = wr_en && !busy;

    always_comb begin
        state_d = state_q;
        if (accept) begin
            unique case (state_q)
                IDLE_READ:      state_d = flags.unlk_a ? GOT_UNLK1 : IDLE_READ;
                GOT_UNLK1:      state_d = flags.unlk_b ? GOT_UNLK2 : IDLE_READ;
                GOT_UNLK2: begin
                    if (flags.pgm)            state_d = PGM_WAIT_DATA;
                    else if (flags.ers_setup) state_d = ERS_ARMED;
                    else if (flags.byp_enter) state_d = BYP_IDLE;
                    else                      state_d = IDLE_READ;
                end
                PGM_WAIT_DATA:  state_d = IDLE_READ;
                ERS_ARMED:      state_d = flags.unlk_a ? ERS_UNLK1 : IDLE_READ;
                ERS_UNLK1:      state_d = flags.unlk_b ? ERS_UNLK2 : IDLE_READ;
                ERS_UNLK2:      state_d = IDLE_READ;
                BYP_IDLE: begin
                    if (flags.pgm)            state_d = BYP_WAIT_DATA;
                    else if (flags.byp_exit1) state_d = BYP_EXIT_ARMED;
                    else                      state_d = BYP_IDLE;
                end
                BYP_WAIT_DATA:  state_d = BYP_IDLE;
                BYP_EXIT_ARMED: state_d = flags.byp_exit2 ? IDLE_READ : BYP_IDLE;
                default:        state_d = IDLE_READ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) state_q <= IDLE_READ;
        else           state_q <= state_d;
    end

    always_comb begin
        fire_prog  = accept && ((state_q == PGM_WAIT_DATA) || (state_q == BYP_WAIT_DATA));
        fire_erase = accept && (state_q == ERS_UNLK2) && flags.chip_ers;
        in_bypass  = (state_q == BYP_IDLE) || (state_q == BYP_WAIT_DATA) ||
                     (state_q == BYP_EXIT_ARMED);
    end

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!hw_rst_n)
        busy |=> $stable(state_q)); // R7
    AST_BYP_EXIT_PATH: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $fell(in_bypass) |-> ($past(state_q) == BYP_EXIT_ARMED)); // R6
endmodule

// File: rtl/nor_op_launch.sv
module nor_op_launch #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              fire_prog,
    input  logic              fire_erase,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prog_start,
    output logic              erase_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);
    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            prog_start  <= 1'b0;
            erase_start <= 1'b0;
            prog_addr   <= '0;
            prog_data   <= '0;
        end else begin
            prog_start  <= fire_prog;
            erase_start <= fire_erase;
            if (fire_prog) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
        end
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !(prog_start && erase_start)); // R9
    AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!hw_rst_n)
        prog_start |=> !prog_start); // R9
    AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!hw_rst_n)
        erase_start |=> !erase_start); // R9
    AST_PROG_NOT_BUSY: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $rose(prog_start) |-> !$past(busy)); // R7
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !prog_start |-> $stable(prog_addr)); // R9
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              prog_start,
    output logic              erase_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              bypass_mode
);
    cyc_flags_t flags;
    logic       fire_prog;
    logic       fire_erase;

    nor_cycle_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_classify (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .flags   (flags)
    );

    nor_cmd_fsm u_fsm (
        .clk        (clk),
        .hw_rst_n   (hw_rst_n),
        .wr_en      (wr_en),
        .busy       (busy),
        .flags      (flags),
        .fire_prog  (fire_prog),
        .fire_erase (fire_erase),
        .in_bypass  (bypass_mode)
    );

    nor_op_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_launch (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .fire_prog   (fire_prog),
        .fire_erase  (fire_erase),
        .busy        (busy),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .prog_start  (prog_start),
        .erase_start (erase_start),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !hw_rst_n |-> (!prog_start && !erase_start && !bypass_mode)); // R1
endmodule

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;
    localparam int AW = 19;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          hw_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic          prog_start;
    logic          erase_start;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;
    logic          bypass_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        bit            is_erase;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    nor_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .hw_rst_n(hw_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .prog_start(prog_start),
        .erase_start(erase_start), .prog_addr(prog_addr), .prog_data(prog_data),
        .bypass_mode(bypass_mode)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(19'h555, 16'h00AA);
        wr(19'h2AA, 16'h0055);
    endtask

    task automatic expect_prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        exp_t e;
        e.is_erase = 1'b0; e.addr = a; e.data = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic expect_erase(input string req);
        exp_t e;
        e.is_erase = 1'b1; e.addr = '0; e.data = '0; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // monitor: pops expected items as pulses appear
    always @(negedge clk) begin
        if (hw_rst_n && (prog_start || erase_start)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected start pulse (prog,erase)",
                      {prog_start, erase_start}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_erase) begin
                    check(erase_start && !prog_start, e.req, "erase pulse",
                          {prog_start, erase_start}, 1);
                end else begin
                    check(prog_start && !erase_start, e.req, "program pulse",
                          {prog_start, erase_start}, 2);
                    check(prog_addr == e.addr, e.req, "prog_addr", prog_addr, e.addr);
                    check(prog_data == e.data, e.req, "prog_data", prog_data, e.data);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        check(bypass_mode == 1'b0, "R1", "bypass_mode in reset", bypass_mode, 0);
        check(prog_start == 1'b0 && erase_start == 1'b0, "R1", "pulses in reset",
              {prog_start, erase_start}, 0);
        hw_rst_n = 1'b1;
        idle(2);
        check(bypass_mode == 1'b0, "R1", "bypass_mode after reset", bypass_mode, 0);

        // R2 standard program
        expect_prog(19'h01234, 16'hBEEF, "R2");
        unlock(); wr(19'h00000, 16'h00A0); wr(19'h01234, 16'hBEEF);
        check(bypass_mode == 1'b0, "R2", "mode after program", bypass_mode, 0);
        // R9 pulse gone and values held
        idle(3);
        check(prog_start == 1'b0, "R9", "prog_start after one cycle", prog_start, 0);
        check(prog_addr == 19'h01234 && prog_data == 16'hBEEF, "R9", "held prog_data",
              prog_data, 16'hBEEF);

        // R3 chip erase, R11 upper data bits ignored
        expect_erase("R3");
        unlock(); wr(19'h555, 16'hFF80); unlock(); wr(19'h555, 16'h3310);
        idle(2);

        // R8 wrong unlock address, then lone A0 + data: nothing
        wr(19'h555, 16'h00AA); wr(19'h123, 16'h0055);
        wr(19'h555, 16'h00A0); wr(19'h00777, 16'h1111);
        // R8 F0 inside erase sequence aborts
        unlock(); wr(19'h555, 16'h0080); wr(19'h555, 16'h00F0);
        wr(19'h2AA, 16'h0055); wr(19'h555, 16'h0010);
        idle(2);
        check(bypass_mode == 1'b0, "R8", "mode after aborted sequences", bypass_mode, 0);
        check(exp_q.size() == 0, "R8", "pending expectations", exp_q.size(), 0);

        // R4 bypass entry
        unlock(); wr(19'h555, 16'h0020);
        check(bypass_mode == 1'b1, "R4", "bypass entered", bypass_mode, 1);

        // R5 bypass programs
        expect_prog(19'h00100, 16'h0F0F, "R5");
        wr(19'h0, 16'h00A0); wr(19'h00100, 16'h0F0F);
        expect_prog(19'h7FFFF, 16'hA5A5, "R5");
        wr(19'h0, 16'h00A0); wr(19'h7FFFF, 16'hA5A5);
        check(bypass_mode == 1'b1, "R5", "bypass kept", bypass_mode, 1);

        // R6 ignored writes in bypass
        unlock(); wr(19'h555, 16'h0080); wr(19'h0, 16'h00F0); wr(19'h0, 16'h0010);
        idle(2);
        check(bypass_mode == 1'b1, "R6", "bypass after foreign writes", bypass_mode, 1);
        wr(19'h0, 16'h0090); wr(19'h0, 16'h0055);
        check(bypass_mode == 1'b1, "R6", "bypass after 90h+55h", bypass_mode, 1);
        wr(19'h0, 16'h0090); wr(19'h0, 16'h0000);
        check(bypass_mode == 1'b0, "R6", "exit bypass", bypass_mode, 0);
        wr(19'h0, 16'h00A0); wr(19'h00200, 16'h2222);
        idle(2);

        // R7 whole sequence while busy
        busy = 1'b1;
        unlock(); wr(19'h0, 16'h00A0); wr(19'h00300, 16'h3333);
        busy = 1'b0;
        idle(2);
        check(bypass_mode == 1'b0, "R7", "mode after busy writes", bypass_mode, 0);
        // R7 busy mid-sequence freezes state
        expect_prog(19'h00400, 16'h4444, "R7");
        unlock();
        busy = 1'b1; wr(19'h0, 16'h0033); busy = 1'b0;
        wr(19'h0, 16'h00A0); wr(19'h00400, 16'h4444);
        idle(2);

        // R10 reset between set-up and data
        unlock(); wr(19'h0, 16'h00A0);
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1;
        wr(19'h00500, 16'h5555);
        // R10 reset in the same cycle as the final write
        unlock(); wr(19'h0, 16'h00A0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 19'h00600; wr_data = 16'h6666; hw_rst_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; hw_rst_n = 1'b1;
        idle(2);
        check(prog_start == 1'b0, "R10", "no pulse after reset collision", prog_start, 0);
        // R10 reset leaves bypass
        unlock(); wr(19'h555, 16'h0020);
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk);
        check(bypass_mode == 1'b0, "R10", "bypass cleared by reset", bypass_mode, 0);
        hw_rst_n = 1'b1;

        // still alive after collisions
        expect_prog(19'h00700, 16'h7777, "R10");
        unlock(); wr(19'h0, 16'h00A0); wr(19'h00700, 16'h7777);
        idle(3);
        check(exp_q.size() == 0, "R9", "all expected pulses seen", exp_q.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule